// File: doc/BRIEF.md
# Sound Coprocessor Address Decoder with Banked Main-Bus Window

This block sits between an 8-bit sound coprocessor with a 16-bit address space and its targets. Each byte access goes to exactly one destination. Low addresses reach a local 8 KB RAM. One address band reaches the FM synthesizer port. A few write-only addresses reach the PSG port. One write-only page feeds a bank register. The top half of the address space is a 32 KB window onto a 24-bit main bus. A 9-bit bank number, loaded one bit per write, supplies the upper address bits of that window.

The coprocessor presents a request with an address, a write flag, a width flag and up to 16 bits of write data. A sequencer state machine splits each request into byte phases. Its states are IDLE, LO_BYTE, HI_BYTE and FINISH:
- Accept (IDLE to LO_BYTE) latches the request.
- Stall keeps LO_BYTE or HI_BYTE unchanged while a forwarded main-bus phase waits for its acknowledge.
- Advance (LO_BYTE to HI_BYTE) is taken only for 16-bit requests.
- Last (LO_BYTE or HI_BYTE to FINISH) ends the byte phases.
- Retire (FINISH to IDLE) follows the cycle in which the result is presented.

The busy output stays high from accept through FINISH, so it acts as the wait signal for the coprocessor.

Top module: `snd_bus_decoder`

## Requirements
- R1: During and right after reset the block is idle: busy, done and every target select are low. The bank register holds zero, so the first forwarded access to 0x8000 produces main-bus address 0x000000.
- R2: A byte access below 0x4000 selects the local RAM with index address[12:0]. Addresses 0x2000 to 0x3FFF therefore reach the same cells as 0x0000 to 0x1FFF.
- R3: A byte access whose address bits [15:13] are 3'b010 (0x4000 to 0x5FFF) selects the FM port, for both reads and writes.
- R4: A byte write whose address ANDed with 0xFFF9 equals 0x7F11 (0x7F11, 0x7F13, 0x7F15, 0x7F17) selects the PSG port and presents the write byte. Reads of those addresses select nothing.
- R5: A byte write with address[15:8] = 0x60 shifts the 9-bit bank register right by one and places write-data bit 0 in bank bit 8. It selects no target.
- R6: A byte access at 0x8000 or above raises the main-bus request with address bank*0x8000 + address[14:0], plus the write flag and the write byte.
- R7: A forwarded phase keeps its request, address and write byte steady and keeps busy high until the acknowledge. The phase completes in the acknowledge cycle.
- R8: A 16-bit request runs as two byte phases: the low byte at address A first, then the high byte at A+1 (wrapping in 16 bits). Write bits [7:0] go with the first phase, and read data returns as {second byte, first byte}.
- R9: Reads of unmapped addresses (0x6000 to 0x7FFF, apart from nothing else) return 0x00. Unmapped writes and bank-page reads select no target.
- R10: At most one of the RAM, FM, PSG and main-bus selects is high in any cycle, and only during a byte phase.
- R11: Done is a one-cycle pulse, high while busy is high, in the cycle after the last byte phase completes. Read data is valid in that cycle, and a narrow read returns 0x00 in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_req | input | 1 | Request strobe, honoured while busy is low |
| cp_we | input | 1 | 1 = write, 0 = read |
| cp_wide | input | 1 | 1 = 16-bit access (two byte phases) |
| cp_addr | input | 16 | Coprocessor byte address |
| cp_wdata | input | 16 | Write data, bits [7:0] go first |
| cp_rdata | output | 16 | Read result, valid while done is high |
| cp_busy | output | 1 | Wait signal to the coprocessor |
| cp_done | output | 1 | Completion pulse |
| loc_addr | output | 16 | Address of the current byte phase |
| loc_wdata | output | 8 | Write byte of the current phase |
| loc_we | output | 1 | Write flag of the current phase |
| ram_cs | output | 1 | Local RAM select |
| ram_rdata | input | 8 | RAM read byte, same cycle as select |
| fm_cs | output | 1 | FM port select |
| fm_rdata | input | 8 | FM read byte, same cycle as select |
| psg_cs | output | 1 | PSG port select (writes only) |
| mb_req | output | 1 | Main-bus request |
| mb_we | output | 1 | Main-bus write flag |
| mb_addr | output | 24 | Main-bus byte address |
| mb_wdata | output | 8 | Main-bus write byte |
| mb_ack | input | 1 | Main-bus acknowledge, completes the phase |
| mb_rdata | input | 8 | Main-bus read byte, valid with acknowledge |

## Verification
The bench sweeps reads and writes across the whole 64 KB space. It checks every address against an arithmetic region model, so a decoder that used a wrong FM prefix, too loose a PSG mask or a whole-page bank match would select the wrong port or none at all. A full RAM fill through alternating mirrors, followed by reads, would expose indexing by more or fewer than 13 bits. A 9-bit serial bank load followed by window reads would expose a shift in the wrong direction or a dropped top bit, because the main-bus address would come out wrong. Wide accesses are aimed at region edges: 0x1FFF, 0x3FFF, 0xFFFF (where the address wraps) and a write pair that both lands on the bank page. These would expose reversed byte order, a missing carry, or a second bank shift that is lost. Acknowledge delays would expose a phase that ends before the acknowledge or an address that moves during the stall.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LO_BYTE,
        ST_HI_BYTE,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_RAM,
        RG_FM,
        RG_PSG,
        RG_BANK,
        RG_BUS
    } region_t;

endpackage

// File: rtl/snd_dec_region.sv
module snd_dec_region
    import snd_dec_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PSG_MASK  = 16'hFFF9,
    parameter logic [15:0] PSG_MATCH = 16'h7F11,
    parameter logic [7:0]  BANK_PAGE = 8'h60,
    parameter logic [2:0]  FM_PREFIX = 3'b010
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output region_t           region
);

    localparam int TOP = ADDR_W - 1;

    logic in_window;
    logic in_ram;
    logic in_fm;
    logic is_psg;
    logic is_bank;

    always_comb begin
        in_window = addr[TOP];
        in_ram    = (addr[TOP:TOP-1] == 2'b00);
        in_fm     = (addr[TOP:TOP-2] == FM_PREFIX);
        is_psg    = we && ((addr & PSG_MASK) == PSG_MATCH);
        is_bank   = we && (addr[TOP:TOP-7] == BANK_PAGE);
    end

    always_comb begin
        if (in_window)    region = RG_BUS;
        else if (in_ram)  region = RG_RAM;
        else if (in_fm)   region = RG_FM;
        else if (is_psg)  region = RG_PSG;
        else if (is_bank) region = RG_BANK;
        else              region = RG_NONE;
    end

endmodule

// File: rtl/snd_dec_bank.sv
module snd_dec_bank #(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [BANK_W-1:0] bank_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (shift_en) begin
            bank_q <= {din, bank_q[BANK_W-1:1]};
        end
    end

endmodule

// File: rtl/snd_dec_seq.sv
module snd_dec_seq
    import snd_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cp_req,
    input  logic                cp_we,
    input  logic                cp_wide,
    input  logic [ADDR_W-1:0]   cp_addr,
    input  logic [2*BYTE_W-1:0] cp_wdata,
    input  logic                byte_ready,
    input  logic [BYTE_W-1:0]   byte_rdata,
    output logic                phase_active,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic [BYTE_W-1:0]   cur_wdata,
    output logic                cur_we,
    output logic                cp_busy,
    output logic                cp_done,
    output logic [2*BYTE_W-1:0] cp_rdata
);

    localparam int WORD_W = 2 * BYTE_W;

    seq_state_t state_q;
    seq_state_t state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic              we_q;
    logic              wide_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cp_req) state_d = ST_LO_BYTE;
            ST_LO_BYTE: if (byte_ready) state_d = wide_q ? ST_HI_BYTE : ST_FINISH;
            ST_HI_BYTE: if (byte_ready) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        phase_active = (state_q == ST_LO_BYTE) || (state_q == ST_HI_BYTE);
        cur_addr     = (state_q == ST_HI_BYTE) ? (addr_q + ADDR_W'(1)) : addr_q;
        cur_wdata    = (state_q == ST_HI_BYTE) ? wdata_q[WORD_W-1:BYTE_W]
                                               : wdata_q[BYTE_W-1:0];
        cur_we       = phase_active && we_q;
        cp_busy      = (state_q != ST_IDLE);
        cp_done      = (state_q == ST_FINISH);
        cp_rdata     = rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            we_q    <= 1'b0;
            wide_q  <= 1'b0;
        end else if (state_q == ST_IDLE && cp_req) begin
            addr_q  <= cp_addr;
            wdata_q <= cp_wdata;
            we_q    <= cp_we;
            wide_q  <= cp_wide;
            rdata_q <= '0;
        end else if (byte_ready && !we_q) begin
            if (state_q == ST_LO_BYTE) rdata_q[BYTE_W-1:0] <= byte_rdata;
            if (state_q == ST_HI_BYTE) rdata_q[WORD_W-1:BYTE_W] <= byte_rdata;
        end
    end

endmodule

// File: rtl/snd_bus_decoder.sv
module snd_bus_decoder
    import snd_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int BANK_W = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cp_req,
    input  logic                         cp_we,
    input  logic                         cp_wide,
    input  logic [ADDR_W-1:0]            cp_addr,
    input  logic [2*BYTE_W-1:0]          cp_wdata,
    output logic [2*BYTE_W-1:0]          cp_rdata,
    output logic                         cp_busy,
    output logic                         cp_done,
    output logic [ADDR_W-1:0]            loc_addr,
    output logic [BYTE_W-1:0]            loc_wdata,
    output logic                         loc_we,
    output logic                         ram_cs,
    input  logic [BYTE_W-1:0]            ram_rdata,
    output logic                         fm_cs,
    input  logic [BYTE_W-1:0]            fm_rdata,
    output logic                         psg_cs,
    output logic                         mb_req,
    output logic                         mb_we,
    output logic [BANK_W+ADDR_W-2:0]     mb_addr,
    output logic [BYTE_W-1:0]            mb_wdata,
    input  logic                         mb_ack,
    input  logic [BYTE_W-1:0]            mb_rdata
);

    localparam int WIN_W = ADDR_W - 1;

    region_t           region;
    logic              phase_active;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0] cur_wdata;
    logic              cur_we;
    logic              byte_ready;
    logic [BYTE_W-1:0] byte_rdata;
    logic              bank_shift;
    logic [BANK_W-1:0] bank_q;

    snd_dec_region #(
        .ADDR_W (ADDR_W)
    ) u_region (
        .addr   (cur_addr),
        .we     (cur_we),
        .region (region)
    );

    snd_dec_bank #(
        .BANK_W (BANK_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bank_shift),
        .din      (cur_wdata[0]),
        .bank_q   (bank_q)
    );

    snd_dec_seq #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cp_req       (cp_req),
        .cp_we        (cp_we),
        .cp_wide      (cp_wide),
        .cp_addr      (cp_addr),
        .cp_wdata     (cp_wdata),
        .byte_ready   (byte_ready),
        .byte_rdata   (byte_rdata),
        .phase_active (phase_active),
        .cur_addr     (cur_addr),
        .cur_wdata    (cur_wdata),
        .cur_we       (cur_we),
        .cp_busy      (cp_busy),
        .cp_done      (cp_done),
        .cp_rdata     (cp_rdata)
    );

    always_comb begin
        ram_cs     = phase_active && (region == RG_RAM);
        fm_cs      = phase_active && (region == RG_FM);
        psg_cs     = phase_active && (region == RG_PSG);
        mb_req     = phase_active && (region == RG_BUS);
        bank_shift = phase_active && (region == RG_BANK);
        byte_ready = phase_active && ((region != RG_BUS) || mb_ack);
        loc_addr   = cur_addr;
        loc_wdata  = cur_wdata;
        loc_we     = cur_we;
        mb_we      = cur_we;
        mb_wdata   = cur_wdata;
        mb_addr    = {bank_q, cur_addr[WIN_W-1:0]};
    end

    always_comb begin
        unique case (region)
            RG_RAM:  byte_rdata = ram_rdata;
            RG_FM:   byte_rdata = fm_rdata;
            RG_BUS:  byte_rdata = mb_rdata;
            default: byte_rdata = '0;
        endcase
    end

endmodule

// File: rtl/snd_dec_chk.sv
module snd_dec_chk #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int BANK_W = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cp_busy,
    input logic                     cp_done,
    input logic [ADDR_W-1:0]        loc_addr,
    input logic [BYTE_W-1:0]        loc_wdata,
    input logic                     loc_we,
    input logic                     ram_cs,
    input logic                     fm_cs,
    input logic                     psg_cs,
    input logic                     mb_req,
    input logic                     mb_ack,
    input logic [BANK_W+ADDR_W-2:0] mb_addr,
    input logic [BYTE_W-1:0]        mb_wdata,
    input logic [BANK_W-1:0]        bank_q
);

    localparam int WIN_W = ADDR_W - 1;

    // R10
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, fm_cs, psg_cs, mb_req}));

    // R10
    select_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs || fm_cs || psg_cs || mb_req) |-> (cp_busy && !cp_done));

    // R2
    ram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> (loc_addr[ADDR_W-1:ADDR_W-2] == 2'b00));

    // R3
    fm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fm_cs |-> (loc_addr[ADDR_W-1:ADDR_W-3] == 3'b010));

    // R4
    psg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psg_cs |-> loc_we);

    // R5
    bank_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_q) |-> $past(cp_busy && loc_we && loc_addr[ADDR_W-1:ADDR_W-8] == 8'h60));

    // R6
    window_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mb_req |-> (loc_addr[ADDR_W-1] && mb_addr[WIN_W-1:0] == loc_addr[WIN_W-1:0]));

    // R7
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && !mb_ack) |=> (mb_req && $stable(mb_addr) && $stable(mb_wdata) && cp_busy));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_done |=> !cp_done);

    // R11
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_done |-> cp_busy);

endmodule

bind snd_bus_decoder snd_dec_chk #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cp_busy   (cp_busy),
    .cp_done   (cp_done),
    .loc_addr  (loc_addr),
    .loc_wdata (loc_wdata),
    .loc_we    (loc_we),
    .ram_cs    (ram_cs),
    .fm_cs     (fm_cs),
    .psg_cs    (psg_cs),
    .mb_req    (mb_req),
    .mb_ack    (mb_ack),
    .mb_addr   (mb_addr),
    .mb_wdata  (mb_wdata),
    .bank_q    (bank_q)
);

// File: tb/snd_bus_decoder_test.sv
`timescale 1ns/1ps
module snd_bus_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_req = 1'b0;
    logic        cp_we = 1'b0;
    logic        cp_wide = 1'b0;
    logic [15:0] cp_addr = '0;
    logic [15:0] cp_wdata = '0;
    logic [15:0] cp_rdata;
    logic        cp_busy, cp_done;
    logic [15:0] loc_addr;
    logic [7:0]  loc_wdata;
    logic        loc_we;
    logic        ram_cs, fm_cs, psg_cs, mb_req, mb_we, mb_ack;
    logic [7:0]  ram_rdata, fm_rdata, mb_rdata, mb_wdata;
    logic [23:0] mb_addr;

    always #2 clk = ~clk;

    snd_bus_decoder uut (
        .clk(clk), .rst_n(rst_n), .cp_req(cp_req), .cp_we(cp_we),
        .cp_wide(cp_wide), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_rdata(cp_rdata), .cp_busy(cp_busy), .cp_done(cp_done),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_we(loc_we),
        .ram_cs(ram_cs), .ram_rdata(ram_rdata), .fm_cs(fm_cs),
        .fm_rdata(fm_rdata), .psg_cs(psg_cs), .mb_req(mb_req),
        .mb_we(mb_we), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
        .mb_ack(mb_ack), .mb_rdata(mb_rdata)
    );

    function automatic logic [7:0] fm_val(input logic [15:0] a);
        return a[7:0] ^ 8'hC3 ^ {a[12:9], 4'h0};
    endfunction

    function automatic logic [7:0] bus_val(input logic [23:0] a);
        return (a[7:0] + a[23:16]) ^ 8'h3C;
    endfunction

    // region codes: 0 none, 1 ram, 2 fm, 3 psg, 4 bank, 5 main bus
    function automatic int exp_rgn(input int a, input bit we);
        if (a >= 32768) return 5;
        if (a < 16384) return 1;
        if (a < 24576) return 2;
        if (we && (a == 'h7F11 || a == 'h7F13 || a == 'h7F15 || a == 'h7F17)) return 3;
        if (we && a >= 24576 && a < 24832) return 4;
        return 0;
    endfunction

    // target models
    logic [7:0] ram_mem [0:8191];
    logic [7:0] exp_mem [0:8191];
    int         ack_lat = 0;
    int         wcnt = 0;
    assign ram_rdata = ram_mem[loc_addr[12:0]];
    assign fm_rdata  = fm_val(loc_addr);
    assign mb_rdata  = bus_val(mb_addr);
    assign mb_ack    = mb_req && (wcnt >= ack_lat);

    // monitor
    int          n_ram = 0, n_fm = 0, n_psg = 0, n_bus = 0, n_ph = 0, n_stall = 0;
    logic [15:0] ph_addr [0:1];
    logic [23:0] last_mb = '0;
    logic [7:0]  last_mbd = '0;
    logic [7:0]  last_psgd = '0;

    always @(posedge clk) begin
        if (mb_req && !mb_ack) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (ram_cs && loc_we) ram_mem[loc_addr[12:0]] <= loc_wdata;
        if (cp_req && !cp_busy) begin
            n_ram <= 0; n_fm <= 0; n_psg <= 0; n_bus <= 0; n_ph <= 0; n_stall <= 0;
        end else begin
            if (ram_cs) n_ram <= n_ram + 1;
            if (fm_cs) n_fm <= n_fm + 1;
            if (psg_cs) begin n_psg <= n_psg + 1; last_psgd <= loc_wdata; end
            if (mb_req && mb_ack) begin
                n_bus <= n_bus + 1; last_mb <= mb_addr; last_mbd <= mb_wdata;
            end
            if (mb_req && !mb_ack) n_stall <= n_stall + 1;
            if (ram_cs || fm_cs || psg_cs || (mb_req && mb_ack)) begin
                if (n_ph < 2) ph_addr[n_ph] <= loc_addr;
                n_ph <= n_ph + 1;
            end
        end
    end

    int         n_cmp = 0, n_bad = 0;
    logic [8:0] bank_m = '0;
    bit         finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input bit wide, input int a,
                          input logic [15:0] wd, output logic [15:0] rd);
        int guard;
        @(negedge clk);
        cp_req = 1'b1; cp_we = we; cp_wide = wide; cp_addr = a[15:0]; cp_wdata = wd;
        @(negedge clk);
        cp_req = 1'b0;
        guard = 0;
        while (!cp_done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 100, "R11", "done never came", guard, 0);
        rd = cp_rdata;
    endtask

    task automatic run(input bit we, input bit wide, input int a,
                       input logic [15:0] wd, input string req);
        int          nb, e_ram, e_fm, e_psg, e_bus, e_nph;
        logic [15:0] e_ph [0:1];
        logic [15:0] e_rd, rd;
        logic [23:0] e_mb;
        logic [7:0]  e_mbd, e_psgd;
        nb = wide ? 2 : 1;
        e_ram = 0; e_fm = 0; e_psg = 0; e_bus = 0; e_nph = 0;
        e_rd = '0; e_mb = '0; e_mbd = '0; e_psgd = '0;
        e_ph[0] = '0; e_ph[1] = '0;
        for (int k = 0; k < nb; k++) begin
            int         ab, rg;
            logic [7:0] bd, rb;
            ab = (a + k) & 65535;
            rg = exp_rgn(ab, we);
            bd = (k == 1) ? wd[15:8] : wd[7:0];
            rb = 8'h00;
            case (rg)
                1: begin
                    e_ram++;
                    if (we) exp_mem[ab & 8191] = bd; else rb = exp_mem[ab & 8191];
                end
                2: begin e_fm++; rb = fm_val(ab[15:0]); end
                3: begin e_psg++; e_psgd = bd; end
                4: bank_m = {bd[0], bank_m[8:1]};
                5: begin
                    e_bus++;
                    e_mb = 24'(bank_m) * 24'd32768 + 24'(ab & 32767);
                    e_mbd = bd;
                    rb = bus_val(e_mb);
                end
                default: ;
            endcase
            if (rg == 1 || rg == 2 || rg == 3 || rg == 5) begin
                e_ph[e_nph] = ab[15:0];
                e_nph++;
            end
            if (!we) e_rd = e_rd | (16'(rb) << (8 * k));
        end
        access(we, wide, a, wd, rd);
        chk(n_ram == e_ram, req, $sformatf("ram selects @%h", a[15:0]), n_ram, e_ram);
        chk(n_fm == e_fm, req, $sformatf("fm selects @%h", a[15:0]), n_fm, e_fm);
        chk(n_psg == e_psg, req, $sformatf("psg selects @%h", a[15:0]), n_psg, e_psg);
        chk(n_bus == e_bus, req, $sformatf("bus phases @%h", a[15:0]), n_bus, e_bus);
        chk(n_stall == ack_lat * e_bus, "R7", $sformatf("stall cycles @%h", a[15:0]),
            n_stall, ack_lat * e_bus);
        chk(n_ph == e_nph, req, $sformatf("phase count @%h", a[15:0]), n_ph, e_nph);
        for (int k = 0; k < e_nph && k < 2; k++)
            chk(ph_addr[k] == e_ph[k], "R8", $sformatf("phase %0d address", k),
                ph_addr[k], e_ph[k]);
        if (!we) chk(rd == e_rd, req, $sformatf("read data @%h", a[15:0]), rd, e_rd);
        if (e_bus > 0) begin
            chk(last_mb == e_mb, "R6", "main-bus address", last_mb, e_mb);
            if (we) chk(last_mbd == e_mbd, "R6", "main-bus write byte", last_mbd, e_mbd);
        end
        if (e_psg > 0) chk(last_psgd == e_psgd, "R4", "psg write byte", last_psgd, e_psgd);
    endtask

    initial begin
        #760000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!cp_busy && !cp_done, "R1", "busy/done in reset", {cp_busy, cp_done}, 0);
        chk(!(ram_cs | fm_cs | psg_cs | mb_req), "R1", "selects in reset",
            {ram_cs, fm_cs, psg_cs, mb_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cp_busy && !cp_done, "R1", "busy/done after reset", {cp_busy, cp_done}, 0);
        // R1: bank starts at zero
        run(1'b0, 1'b0, 'h8000, 16'h0, "R1");
        chk(last_mb == 24'h000000, "R1", "first window address", last_mb, 0);

        // R2: fill RAM through alternating mirrors
        for (int i = 0; i < 8192; i++)
            run(1'b1, 1'b0, i | ((i & 1) ? 'h2000 : 0), 16'((i * 5 + 3) ^ (i >> 7)), "R2");

        // R2 R3 R6 R9: read sweep over the whole space
        for (int a = 0; a < 65536; a += 13) begin
            string r;
            case (exp_rgn(a, 1'b0))
                1: r = "R2"; 2: r = "R3"; 5: r = "R6"; default: r = "R9";
            endcase
            run(1'b0, 1'b0, a, 16'h0, r);
        end

        // write sweep: R2 R3 R5 R6 R9
        for (int a = 7; a < 65536; a += 97)
            run(1'b1, 1'b0, a, 16'(a ^ 'h5A5A), "R9");

        // R4 psg decode
        run(1'b1, 1'b0, 'h7F11, 16'h0091, "R4");
        run(1'b1, 1'b0, 'h7F13, 16'h0013, "R4");
        run(1'b1, 1'b0, 'h7F15, 16'h00A5, "R4");
        run(1'b1, 1'b0, 'h7F17, 16'h0077, "R4");
        run(1'b1, 1'b0, 'h7F10, 16'h0011, "R4");
        run(1'b1, 1'b0, 'h7F19, 16'h0022, "R4");
        run(1'b1, 1'b0, 'h7F31, 16'h0033, "R4");
        run(1'b1, 1'b0, 'h7E11, 16'h0044, "R4");
        run(1'b0, 1'b0, 'h7F11, 16'h0000, "R4");

        // R5 serial bank load, then window reads and writes
        for (int k = 0; k < 9; k++)
            run(1'b1, 1'b0, 'h6000 + k * 17, 16'((9'h1A5 >> k) & 1) | 16'h00FE, "R5");
        chk(bank_m == 9'h1A5, "R5", "bench bank model", bank_m, 9'h1A5);
        run(1'b0, 1'b0, 'h8000, 16'h0, "R5");
        chk(last_mb == 24'(9'h1A5) << 15, "R5", "window base after load", last_mb,
            24'(9'h1A5) << 15);
        run(1'b0, 1'b0, 'hFFFE, 16'h0, "R6");
        run(1'b1, 1'b0, 'hC321, 16'h00E7, "R6");
        run(1'b0, 1'b0, 'h60AA, 16'h0, "R9");
        run(1'b0, 1'b0, 'h8001, 16'h0, "R5");

        // R7 stalled forwarding
        ack_lat = 3;
        run(1'b0, 1'b0, 'hC123, 16'h0, "R7");
        run(1'b1, 1'b0, 'h9ABC, 16'h00D2, "R7");
        run(1'b0, 1'b1, 'hA000, 16'h0, "R7");
        ack_lat = 1;
        run(1'b1, 1'b1, 'hFFFF, 16'h6B4C, "R7");
        ack_lat = 0;

        // R8 wide accesses at region edges
        run(1'b0, 1'b1, 'h1FFF, 16'h0, "R8");
        run(1'b0, 1'b1, 'h3FFF, 16'h0, "R8");
        run(1'b0, 1'b1, 'hFFFF, 16'h0, "R8");
        run(1'b1, 1'b1, 'h0100, 16'hBEEF, "R8");
        run(1'b0, 1'b1, 'h2100, 16'h0, "R8");
        run(1'b1, 1'b1, 'h6010, 16'h0100, "R8");
        run(1'b0, 1'b0, 'h8000, 16'h0, "R8");
        run(1'b1, 1'b1, 'h7F10, 16'h5A00, "R8");
        run(1'b0, 1'b1, 'h5FFF, 16'h0, "R8");

        // R9 unmapped
        run(1'b0, 1'b0, 'h6000, 16'h0, "R9");
        run(1'b0, 1'b0, 'h7000, 16'h0, "R9");
        run(1'b1, 1'b0, 'h7000, 16'h00FF, "R9");
        run(1'b0, 1'b1, 'h7FFF, 16'h0, "R9");

        // R11 narrow read upper byte and idle after done
        run(1'b0, 1'b0, 'h4001, 16'h0, "R11");
        @(negedge clk);
        chk(!cp_busy && !cp_done, "R11", "idle after retire", {cp_busy, cp_done}, 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule